// File: doc/BRIEF.md
# Link Frame Encoder with Redundant Header

This block builds the transmit frames of a fixed-latency optical link. On every bunch-crossing tick it takes one 64-bit user word. When the user presents nothing, it takes a fixed idle word instead. The word is first scrambled with a self-synchronising scrambler for DC balance. A 16-bit Reed-Solomon check field is then computed over the scrambled payload. An 8-bit header goes in front of the result. The header tells data frames from idle frames and gives the receiver a pattern to lock on. The finished 88-bit frame goes to the serializer. Useful payload is 64 of the 88 bits.

Two static controls let the integrator switch off the scrambler or the code stage, which helps during bring-up and link tests. The frame is registered once, so the latency is one clock from the tick. A strobe marks the cycle in which a new frame appears. The frame then holds its value until the next tick.

Top module: `link_frame_encoder`

## Requirements
- R1: After reset is released, a rising clock edge with `bx_tick` high captures a frame, and `frame_vld` is high for exactly the following cycle. `frame_vld` is low in every cycle that does not follow a capture.
- R2: While `bx_tick` is low, `frame_o` keeps its value whatever the other inputs do.
- R3: The frame layout is fixed: header in `frame_o[87:80]`, check field in `frame_o[79:64]`, payload in `frame_o[63:0]`.
- R4: The header is 8'hA5 when `in_valid` was high at capture and 8'h5A when it was low.
- R5: When `in_valid` is low, the source word is the idle word 64'h0F0F_3C3C_C3C3_F0F0 and `in_data` is ignored.
- R6: Scrambling is defined on a bit stream in which bit 0 of a word comes first and the bits of the previous captured word come before it. Scrambled bit s[i] = d[i] ^ s[i-39] ^ s[i-58]. The scrambler history is the last scrambled word. It resets to zero and is updated at every capture, including captures with the scrambler bypassed.
- R7: With `bypass_scr` high at capture, the payload is the unscrambled source word.
- R8: The check field comes from a code over GF(16) with polynomial x^4+x+1 and primitive element 4'h2. Payload symbol j is `payload[4j+3:4j]`. The check field is {P3,P2,P1,P0}, and the codeword is c(x) = sum of Dj·x^(j+4) plus sum of Pk·x^k. Every codeword evaluates to zero at α^1, α^2, α^3 and α^4. The code is computed over the transmitted payload.
- R9: With `bypass_fec` high at capture, the check field is all zeros.
- R10: During reset, `frame_o` is zero and `frame_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bx_tick | input | 1 | Bunch-crossing capture enable |
| in_valid | input | 1 | User word present; low selects the idle word |
| in_data | input | 64 | User payload word |
| bypass_scr | input | 1 | Send the payload unscrambled |
| bypass_fec | input | 1 | Send the check field as zeros |
| frame_o | output | 88 | Header, check field and payload |
| frame_vld | output | 1 | One-cycle strobe for a new frame |

## Verification
The hardest case to reach from the ports is the scrambler history after a frame captured in scrambler bypass. The output of that frame does not reveal the history, so a wrong update only shows up in the next frame. The bench sends a bypassed frame and then a scrambled frame. It also sends an idle frame straight after a data frame. Both cases are checked against an independent stream model. The check field is judged by evaluating the received codeword at the four roots rather than by repeating the division.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

   localparam int SYM_W    = 4;
   localparam int MAX_NPAR = 8;

   // multiply in GF(16) reduced by x^4 + x + 1
   function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] acc;
      logic [3:0] sh;
      acc = 4'h0;
      sh  = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[3] ? ({sh[2:0], 1'b0} ^ 4'h3) : {sh[2:0], 1'b0};
      end
      return acc;
   endfunction

   // non-leading coefficients of prod (x + a^r), r = 1..npar; coef k at [4k+3:4k]
   function automatic logic [SYM_W*MAX_NPAR-1:0] rs_gen_coefs(input int npar);
      logic [3:0] g [0:MAX_NPAR];
      logic [3:0] root;
      logic [SYM_W*MAX_NPAR-1:0] res;
      for (int k = 0; k <= MAX_NPAR; k++) g[k] = 4'h0;
      g[0] = 4'h1;
      root = 4'h1;
      for (int r = 1; r <= npar; r++) begin
         root = gf16_mul(root, 4'h2);
         for (int k = r; k >= 1; k--) g[k] = g[k-1] ^ gf16_mul(g[k], root);
         g[0] = gf16_mul(g[0], root);
      end
      res = '0;
      for (int k = 0; k < npar; k++) res[SYM_W*k +: SYM_W] = g[k];
      return res;
   endfunction

endpackage

// File: rtl/fenc_scrambler.sv
module fenc_scrambler #(
   parameter int W     = 64,
   parameter int TAP_A = 39,
   parameter int TAP_B = 58
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (TAP_A < 1 || TAP_A >= TAP_B) begin : g_bad_taps
         $error("fenc_scrambler: need 1 <= TAP_A < TAP_B");
      end
      if (TAP_B > W) begin : g_bad_span
         $error("fenc_scrambler: TAP_B must not exceed W so one word resynchronises");
      end
   endgenerate

   logic [W-1:0] hist_q;

   always_comb begin
      logic [2*W-1:0] ext;
      ext = {{W{1'b0}}, hist_q};
      for (int i = 0; i < W; i++) begin
         ext[W+i] = din[i] ^ ext[W+i-TAP_A] ^ ext[W+i-TAP_B];
      end
      dout = ext[2*W-1:W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hist_q <= '0;
      else if (adv) hist_q <= dout;
   end

   // R6: history only moves on a capture
   a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(hist_q));

endmodule

// File: rtl/fenc_rs_parity.sv
module fenc_rs_parity #(
   parameter int NSYM = 16,
   parameter int NPAR = 4
) (
   input  logic [lfe_pkg::SYM_W*NSYM-1:0] data,
   output logic [lfe_pkg::SYM_W*NPAR-1:0] parity
);
   import lfe_pkg::*;

   localparam logic [SYM_W*MAX_NPAR-1:0] G = rs_gen_coefs(NPAR);

   generate
      if (NPAR < 1 || NPAR > MAX_NPAR) begin : g_bad_npar
         $error("fenc_rs_parity: NPAR out of range");
      end
      if (NSYM < 1) begin : g_bad_nsym
         $error("fenc_rs_parity: NSYM must be positive");
      end
   endgenerate

   // systematic division, unrolled over all data symbols, highest degree first
   always_comb begin
      logic [SYM_W*NPAR-1:0] p;
      logic [3:0]            fb;
      p = '0;
      for (int j = NSYM - 1; j >= 0; j--) begin
         fb = data[SYM_W*j +: SYM_W] ^ p[SYM_W*(NPAR-1) +: SYM_W];
         for (int k = NPAR - 1; k >= 1; k--) begin
            p[SYM_W*k +: SYM_W] = p[SYM_W*(k-1) +: SYM_W] ^ gf16_mul(fb, G[SYM_W*k +: SYM_W]);
         end
         p[SYM_W-1:0] = gf16_mul(fb, G[SYM_W-1:0]);
      end
      parity = p;
   end

endmodule

// File: rtl/link_frame_encoder.sv
module link_frame_encoder #(
   parameter int          PAY_W     = 64,
   parameter int          NPAR      = 4,
   parameter int          HDR_W     = 8,
   parameter logic [7:0]  HDR_DATA  = 8'hA5,
   parameter logic [7:0]  HDR_IDLE  = 8'h5A,
   parameter logic [63:0] IDLE_WORD = 64'h0F0F_3C3C_C3C3_F0F0,
   parameter int          TAP_A     = 39,
   parameter int          TAP_B     = 58
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     bx_tick,
   input  logic                                     in_valid,
   input  logic [PAY_W-1:0]                         in_data,
   input  logic                                     bypass_scr,
   input  logic                                     bypass_fec,
   output logic [HDR_W+lfe_pkg::SYM_W*NPAR+PAY_W-1:0] frame_o,
   output logic                                     frame_vld
);
   import lfe_pkg::*;

   localparam int CHK_W = SYM_W * NPAR;
   localparam int NSYM  = PAY_W / SYM_W;
   localparam int FRM_W = HDR_W + CHK_W + PAY_W;
   localparam int CHK_L = PAY_W;
   localparam int HDR_L = PAY_W + CHK_W;

   generate
      if (PAY_W % SYM_W != 0) begin : g_bad_pay
         $error("link_frame_encoder: PAY_W must be a multiple of the symbol width");
      end
      if (PAY_W > 64) begin : g_bad_idle
         $error("link_frame_encoder: PAY_W wider than the idle word");
      end
      if (HDR_W != 8) begin : g_bad_hdr
         $error("link_frame_encoder: header constants are 8 bits");
      end
      if (HDR_DATA == HDR_IDLE) begin : g_same_hdr
         $error("link_frame_encoder: headers must differ");
      end
   endgenerate

   logic [PAY_W-1:0] src_w;
   logic [PAY_W-1:0] scr_w;
   logic [PAY_W-1:0] pay_w;
   logic [CHK_W-1:0] par_w;
   logic [CHK_W-1:0] chk_w;
   logic [HDR_W-1:0] hdr_w;
   logic [FRM_W-1:0] frame_q;
   logic             vld_q;

   assign src_w = in_valid ? in_data : IDLE_WORD[PAY_W-1:0];

   fenc_scrambler #(.W(PAY_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (bx_tick),
      .din   (src_w),
      .dout  (scr_w)
   );

   assign pay_w = bypass_scr ? src_w : scr_w;

   fenc_rs_parity #(.NSYM(NSYM), .NPAR(NPAR)) u_rs (
      .data   (pay_w),
      .parity (par_w)
   );

   assign chk_w = bypass_fec ? '0 : par_w;
   assign hdr_w = in_valid ? HDR_DATA : HDR_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= bx_tick;
         if (bx_tick) frame_q <= {hdr_w, chk_w, pay_w};
      end
   end

   assign frame_o   = frame_q;
   assign frame_vld = vld_q;

   a_r1_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      bx_tick |=> frame_vld);
   a_r1_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_tick |=> !frame_vld);
   a_r2_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_tick |=> $stable(frame_o));
   a_r4_header_kind: assert property (@(posedge clk) disable iff (!rst_n)
      bx_tick |=> (frame_o[FRM_W-1:HDR_L] == ($past(in_valid) ? HDR_DATA : HDR_IDLE)));
   a_r7_raw_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_tick && bypass_scr && in_valid) |=> (frame_o[PAY_W-1:0] == $past(in_data)));
   a_r9_zero_check: assert property (@(posedge clk) disable iff (!rst_n)
      (bx_tick && bypass_fec) |=> (frame_o[HDR_L-1:CHK_L] == '0));

endmodule

// File: tb/sim_link_frame_encoder.sv
`timescale 1ns/1ps
module sim_link_frame_encoder;

   localparam logic [63:0] IDLE = 64'h0F0F_3C3C_C3C3_F0F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bx_tick = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic        bypass_scr = 1'b0;
   logic        bypass_fec = 1'b0;
   logic [87:0] frame_o;
   logic        frame_vld;

   int n_chk = 0;
   int n_bad = 0;
   logic [63:0] m_hist = '0;

   always #10 clk = ~clk;

   link_frame_encoder u0 (
      .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .in_valid(in_valid),
      .in_data(in_data), .bypass_scr(bypass_scr), .bypass_fec(bypass_fec),
      .frame_o(frame_o), .frame_vld(frame_vld)
   );

   task automatic check(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] fmul(input logic [3:0] a, input logic [3:0] b);
      logic [7:0] prod = '0;
      for (int i = 0; i < 4; i++) if (b[i]) prod = prod ^ (8'(a) << i);
      for (int i = 7; i >= 4; i--) if (prod[i]) prod = prod ^ (8'h13 << (i - 4));
      return prod[3:0];
   endfunction

   // bit stream model: previous word precedes current, bit 0 first
   function automatic logic [63:0] scramble(input logic [63:0] d, input logic [63:0] prev);
      logic [63:0] s;
      for (int i = 0; i < 64; i++) begin
         logic a, b;
         a = (i >= 39) ? s[i-39] : prev[64+i-39];
         b = (i >= 58) ? s[i-58] : prev[64+i-58];
         s[i] = d[i] ^ a ^ b;
      end
      return s;
   endfunction

   // true when the codeword has zeros at alpha^1..alpha^4
   function automatic bit roots_ok(input logic [15:0] chk, input logic [63:0] pay);
      logic [3:0] x = 4'h1;
      bit ok = 1'b1;
      for (int r = 1; r <= 4; r++) begin
         logic [3:0] acc = 4'h0;
         x = fmul(x, 4'h2);
         for (int d = 19; d >= 0; d--) begin
            logic [3:0] c;
            c = (d >= 4) ? pay[4*(d-4) +: 4] : chk[4*d +: 4];
            acc = fmul(acc, x) ^ c;
         end
         if (acc != 4'h0) ok = 1'b0;
      end
      return ok;
   endfunction

   // one capture, checked on the following negedge
   task automatic send(input bit v, input logic [63:0] d, input bit bs, input bit bf, input string tag);
      logic [63:0] src, scr, pay;
      logic [7:0]  hdr;
      @(negedge clk);
      bx_tick = 1'b1; in_valid = v; in_data = d; bypass_scr = bs; bypass_fec = bf;
      src = v ? d : IDLE;
      scr = scramble(src, m_hist);
      m_hist = scr;
      pay = bs ? src : scr;
      hdr = v ? 8'hA5 : 8'h5A;
      @(negedge clk);
      bx_tick = 1'b0;
      check(frame_vld === 1'b1, {"R1 strobe ", tag}, 88'(frame_vld), 88'd1);
      check(frame_o[87:80] === hdr, {"R4 header ", tag}, 88'(frame_o[87:80]), 88'(hdr));
      check(frame_o[63:0] === pay, {"R3/R6/R7 payload ", tag}, 88'(frame_o[63:0]), 88'(pay));
      if (bf)
         check(frame_o[79:64] === 16'h0, {"R9 check field ", tag}, 88'(frame_o[79:64]), 88'd0);
      else
         check(roots_ok(frame_o[79:64], frame_o[63:0]) && frame_o[79:64] !== 16'h0 || pay == 64'h0,
               {"R8 codeword roots ", tag}, 88'(frame_o[79:64]), 88'd0);
   endtask

   task automatic t_reset();
      check(frame_o === 88'h0, "R10 frame in reset", frame_o, 88'h0);
      check(frame_vld === 1'b0, "R10 strobe in reset", 88'(frame_vld), 88'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(frame_vld === 1'b0, "R1 no strobe without tick", 88'(frame_vld), 88'h0);
   endtask

   task automatic t_data();
      send(1, 64'h0123_4567_89AB_CDEF, 0, 0, "data a");
      send(1, 64'hFFFF_0000_FFFF_0000, 0, 0, "data b");
      send(1, 64'h0, 0, 0, "data zero");
   endtask

   task automatic t_idle();
      send(0, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, "R5 idle after data");
      send(0, 64'h1111_2222_3333_4444, 1, 0, "R5 idle raw");
      check(frame_o[63:0] === IDLE, "R5 idle word ignores in_data", 88'(frame_o[63:0]), 88'(IDLE));
   endtask

   task automatic t_bypass();
      send(1, 64'hA5A5_5A5A_0F0F_F0F0, 1, 0, "R7 scr bypass");
      send(1, 64'h8000_0000_0000_0001, 0, 0, "R6 history after bypass");
      send(1, 64'h1357_9BDF_2468_ACE0, 0, 1, "R9 fec bypass");
      send(0, 64'h0, 1, 1, "both bypass");
   endtask

   task automatic t_hold();
      logic [87:0] snap;
      snap = frame_o;
      @(negedge clk);
      in_valid = 1'b1; in_data = 64'hCAFE_F00D_CAFE_F00D; bypass_scr = 1'b1; bypass_fec = 1'b0;
      check(frame_vld === 1'b0, "R1 single-cycle strobe", 88'(frame_vld), 88'h0);
      repeat (3) @(negedge clk);
      check(frame_o === snap, "R2 frame holds without tick", frame_o, snap);
      check(frame_vld === 1'b0, "R1 strobe stays low", 88'(frame_vld), 88'h0);
      send(1, 64'h0000_0000_0000_0010, 1, 0, "R8 single symbol");
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_data();
      t_idle();
      t_bypass();
      t_hold();
      report();
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
   end

endmodule